// File: doc/BRIEF.md
# Serial Display Command and Data Transmitter

This block sends bytes to a display controller over a four-wire, write-only serial link. The four lines are an active-low select, a command/data flag, a serial clock and a serial data line. A host pulses `start` with a mode bit and a byte count. The block then pulls the bytes it needs from a valid/ready byte stream and shifts each one out most significant bit first. The display samples one bit on every rising clock edge.

In command mode a frame carries exactly one byte, with the flag low. In data mode a frame carries `byte_count` bytes back to back, with the flag high and the select held low for the whole burst. The display reads the flag at the eighth rising edge of each byte, so the flag is held constant for the whole frame.

A programmable half period sets the serial clock rate. It gives the number of system clock cycles in each low phase and each high phase. After the last bit, every line returns to its idle-high level and `busy` drops.

Top module: `serial_disp_tx`

## Requirements
- R1: After reset and whenever `busy` is 0, `lcd_cs_n`, `lcd_dc`, `lcd_sck` and `lcd_sdo` are all 1.
- R2: When `start` is 1 while idle with a non-zero `byte_count`, the following cycle shows `busy`=1, `lcd_cs_n`=0, `lcd_sck`=0 and `lcd_sdo`=1. In the same cycle `lcd_dc` equals `is_data`, where 1 means data and 0 means command.
- R3: When `start` is 1 while idle with `byte_count`=0, no transfer begins: `busy` stays 0 and all lines stay at their idle levels.
- R4: Each byte is sent bit 7 first and bit 0 last, one bit per rising edge of `lcd_sck`. `lcd_sdo` changes only while `lcd_sck` is low.
- R5: Let P be `half_period` as latched at start, with 0 treated as 1. Every high phase of `lcd_sck` lasts exactly P cycles, and every low phase lasts at least P cycles.
- R6: A command frame (`is_data`=0) sends exactly one byte with `lcd_dc`=0, whatever the non-zero `byte_count`.
- R7: A data frame (`is_data`=1) sends exactly `byte_count` bytes with `lcd_dc`=1. `lcd_cs_n` stays low from the first bit to the last.
- R8: `in_ready` is 1 only while the block waits inside a frame for its next byte. A byte is taken when `in_valid` and `in_ready` are both 1. While the stream stalls, `lcd_sck` stays low and `lcd_cs_n` stays low.
- R9: `busy` falls, and all lines return high, right after the high phase of the frame's last bit. A `start` pulse during a frame is ignored.
- R10: `lcd_dc` does not change while `lcd_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| is_data | input | 1 | Frame mode: 1 data burst, 0 single command |
| byte_count | input | CNT_W | Bytes in a data frame; 0 starts nothing |
| half_period | input | DIV_W | System cycles per serial clock phase (0 acts as 1) |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | BYTE_W | Byte stream payload |
| in_ready | output | 1 | Block can take a byte this cycle |
| busy | output | 1 | Frame in progress |
| lcd_cs_n | output | 1 | Active-low display select |
| lcd_dc | output | 1 | Command (0) / data (1) flag |
| lcd_sck | output | 1 | Serial clock, idle high |
| lcd_sdo | output | 1 | Serial data, idle high |

## Verification
A frame's select, flag and clock levels appear one cycle after the edge that samples `start`. A byte's first bit appears one cycle after its handshake edge. Each bit then takes 2P cycles, and the lines go idle P cycles after the last rising edge. The bench samples every output on the falling clock edge, so each sample holds the value from the preceding rising edge. It checks the launch levels at the first falling edge after `start`. A line monitor counts the samples in each clock phase against P and rebuilds each byte at its rising edges. The bench compares the rebuilt bytes only once `busy` has been seen low.

// File: rtl/serial_disp_tx_pkg.sv
package serial_disp_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } tx_state_e;

  // Cycles per serial clock phase; a zero setting behaves as one.
  function automatic logic [15:0] phase_ticks(input logic [15:0] setting);
    return (setting == 16'd0) ? 16'd1 : setting;
  endfunction

  // Bytes a frame carries: none for a zero request, one for a command.
  function automatic logic [15:0] frame_len(input logic data_mode,
                                            input logic [15:0] request);
    if (request == 16'd0) return 16'd0;
    if (!data_mode)       return 16'd1;
    return request;
  endfunction

endpackage

// File: rtl/serial_disp_tx_phase.sv
module serial_disp_tx_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] ticks,
  output logic             phase_end
);

  logic [DIV_W-1:0] cnt;

  assign phase_end = run && (cnt == ticks - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || phase_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/serial_disp_tx_shifter.sv
module serial_disp_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              msb,
  output logic              last_bit
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  bit_idx;

  assign msb      = shreg[BYTE_W-1];
  assign last_bit = (bit_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      bit_idx <= '0;
    end else if (preset) begin
      shreg   <= '1;
      bit_idx <= '0;
    end else if (load) begin
      shreg   <= din;
      bit_idx <= '0;
    end else if (shift) begin
      shreg   <= {shreg[BYTE_W-2:0], 1'b1};
      bit_idx <= bit_idx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/serial_disp_tx.sv
module serial_disp_tx
  import serial_disp_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_data,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              lcd_cs_n,
  output logic              lcd_dc,
  output logic              lcd_sck,
  output logic              lcd_sdo
);

  tx_state_e        state;
  logic [CNT_W-1:0] left;
  logic             mode_r;
  logic [DIV_W-1:0] ticks_r;

  logic [CNT_W-1:0] req_len;
  logic             launch;
  logic             byte_take;
  logic             phase_end;
  logic             bit_last;
  logic             cur_msb;
  logic             frame_last;
  logic             next_bit;
  logic             byte_done;
  logic             frame_done;
  logic             timer_run;

  assign req_len    = CNT_W'(frame_len(is_data, 16'(byte_count)));
  assign launch     = start && (state == ST_IDLE) && (req_len != '0);
  assign in_ready   = (state == ST_WAIT);
  assign byte_take  = in_valid && in_ready;
  assign timer_run  = (state == ST_LOW) || (state == ST_HIGH);
  assign frame_last = (left == CNT_W'(1));
  assign next_bit   = (state == ST_HIGH) && phase_end && !bit_last;
  assign byte_done  = (state == ST_HIGH) && phase_end && bit_last;
  assign frame_done = byte_done && frame_last;

  serial_disp_tx_phase #(.DIV_W(DIV_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (timer_run),
    .ticks     (ticks_r),
    .phase_end (phase_end)
  );

  serial_disp_tx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (launch),
    .load     (byte_take),
    .shift    (next_bit),
    .din      (in_data),
    .msb      (cur_msb),
    .last_bit (bit_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      left    <= '0;
      mode_r  <= 1'b1;
      ticks_r <= DIV_W'(1);
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state   <= ST_WAIT;
          left    <= req_len;
          mode_r  <= is_data;
          ticks_r <= DIV_W'(phase_ticks(16'(half_period)));
        end
        ST_WAIT: if (byte_take) state <= ST_LOW;
        ST_LOW:  if (phase_end) state <= ST_HIGH;
        ST_HIGH: if (phase_end) begin
          if (!bit_last) begin
            state <= ST_LOW;
          end else if (frame_done) begin
            state <= ST_IDLE;
            left  <= '0;
          end else begin
            state <= ST_WAIT;
            left  <= left - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign lcd_cs_n = (state == ST_IDLE);
  assign lcd_sck  = (state == ST_IDLE) || (state == ST_HIGH);
  assign lcd_sdo  = (state == ST_IDLE) ? 1'b1 : cur_msb;
  assign lcd_dc   = (state == ST_IDLE) ? 1'b1 : mode_r;

endmodule

// File: rtl/serial_disp_tx_chk.sv
module serial_disp_tx_chk #(
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             is_data,
  input logic [CNT_W-1:0] byte_count,
  input logic             in_ready,
  input logic             busy,
  input logic             lcd_cs_n,
  input logic             lcd_dc,
  input logic             lcd_sck,
  input logic             lcd_sdo
);

  logic sck_q;
  int   rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b1;
      rise_cnt <= 0;
    end else begin
      sck_q <= lcd_sck;
      if (lcd_cs_n)                rise_cnt <= 0;
      else if (lcd_sck && !sck_q)  rise_cnt <= rise_cnt + 1;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && lcd_dc && lcd_sck && lcd_sdo));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count != '0) |=>
      (busy && !lcd_cs_n && !lcd_sck && lcd_sdo && (lcd_dc == $past(is_data))));

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> (!busy && lcd_cs_n));

  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_sck && !lcd_cs_n && $past(lcd_sck) && $past(!lcd_cs_n)) |-> $stable(lcd_sdo));

  assert_cmd_one_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_cs_n) && $past(!lcd_dc)) |-> (rise_cnt == BYTE_W));

  assert_whole_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs_n) |-> ((rise_cnt != 0) && (rise_cnt % BYTE_W == 0)));

  assert_ready_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !lcd_cs_n && !lcd_sck));

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_cs_n) |-> (!busy && $past(lcd_sck)));

  assert_dc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_dc));

endmodule

bind serial_disp_tx serial_disp_tx_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .is_data    (is_data),
  .byte_count (byte_count),
  .in_ready   (in_ready),
  .busy       (busy),
  .lcd_cs_n   (lcd_cs_n),
  .lcd_dc     (lcd_dc),
  .lcd_sck    (lcd_sck),
  .lcd_sdo    (lcd_sdo)
);

// File: tb/serial_disp_tx_bench.sv
module serial_disp_tx_bench;

  localparam int DIV_W  = 8;
  localparam int CNT_W  = 8;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              is_data = 1'b0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [DIV_W-1:0]  half_period = '0;
  logic              in_valid = 1'b0;
  logic [BYTE_W-1:0] in_data = '0;
  logic              in_ready, busy, lcd_cs_n, lcd_dc, lcd_sck, lcd_sdo;

  serial_disp_tx #(.DIV_W(DIV_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_serial_disp_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .is_data(is_data),
    .byte_count(byte_count), .half_period(half_period),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_sck(lcd_sck), .lcd_sdo(lcd_sdo)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_p(input int hp);
    return (hp == 0) ? 1 : hp;
  endfunction

  // Line monitor: rebuilds bytes at rising sck, measures phase lengths.
  int          cur_p = 1;
  logic        prev_sck = 1'b1, prev_cs = 1'b1, prev_sdo = 1'b1;
  int          hi_cnt = 0, lo_cnt = 0, rx_bits = 0, rx_n = 0;
  int          phase_err = 0, cs_rises = 0;
  logic [7:0]  rx_sh = '0;
  logic [7:0]  rx_byte [0:15];
  logic        rx_dc   [0:15];

  always @(negedge clk) begin
    if (!lcd_cs_n) begin
      if (lcd_sck) begin
        if (!prev_sck || prev_cs) begin
          if (lo_cnt < cur_p) phase_err++;
          rx_sh = {rx_sh[6:0], lcd_sdo};
          rx_bits++;
          hi_cnt = 1;
          if (rx_bits == 8) begin
            if (rx_n < 16) begin
              rx_byte[rx_n] = rx_sh;
              rx_dc[rx_n]   = lcd_dc;
            end
            rx_n++;
            rx_bits = 0;
          end
        end else begin
          hi_cnt++;
          if (lcd_sdo != prev_sdo) phase_err++;
        end
      end else begin
        if (prev_sck && !prev_cs && hi_cnt != cur_p) phase_err++;
        if (prev_sck) lo_cnt = 1;
        else          lo_cnt++;
      end
    end else if (!prev_cs) begin
      cs_rises++;
      if (!prev_sck || hi_cnt != cur_p) phase_err++;
    end
    prev_sck = lcd_sck;
    prev_cs  = lcd_cs_n;
    prev_sdo = lcd_sdo;
  end

  task automatic do_xfer(input logic m, input int cnt, input int hp,
                         input int max_gap, input bit poke, input int pat);
    logic [7:0] tx [0:15];
    int nexp;
    int waitc;
    nexp = (cnt == 0) ? 0 : (m ? cnt : 1);
    for (int i = 0; i < 16; i++) begin
      if (pat == 1)      tx[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
      else if (pat == 2) tx[i] = (i % 2 == 0) ? 8'hA5 : 8'h5A;
      else               tx[i] = 8'($urandom);
    end
    @(posedge clk);
    rx_n = 0; rx_bits = 0; phase_err = 0; cs_rises = 0;
    cur_p = eff_p(hp);
    @(negedge clk);
    start = 1'b1; is_data = m; byte_count = CNT_W'(cnt); half_period = DIV_W'(hp);
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      // R3: nothing launches on a zero count
      chk(!busy && lcd_cs_n && lcd_sck && lcd_sdo && lcd_dc, "R3 zero count idle",
          {busy, lcd_cs_n, lcd_sck, lcd_sdo, lcd_dc}, 5'b01111);
      repeat (4) @(negedge clk);
      chk(!busy && lcd_cs_n && !in_ready, "R3 still idle", {busy, lcd_cs_n}, 2'b01);
      return;
    end
    // R2: launch levels one cycle after start
    chk(busy && !lcd_cs_n && !lcd_sck && lcd_sdo && (lcd_dc == m), "R2 launch levels",
        {busy, lcd_cs_n, lcd_sck, lcd_sdo, lcd_dc}, {4'b1001, m});
    for (int i = 0; i < nexp; i++) begin
      int gap;
      gap = int'($urandom % (max_gap + 1));
      waitc = 0;
      while (!in_ready && waitc < 5000) begin
        @(negedge clk);
        waitc++;
      end
      chk(in_ready, "R8 ready reached", in_ready, 1);
      for (int g = 0; g < gap; g++) begin
        chk(in_ready && !lcd_sck && !lcd_cs_n, "R8 stall holds sck low",
            {in_ready, lcd_sck, lcd_cs_n}, 3'b100);
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = tx[i];
      @(negedge clk);
      in_valid = 1'b0;
      chk(!in_ready, "R8 ready drops after take", in_ready, 0);
      if (poke && i == 0) begin
        start = 1'b1; is_data = ~m; byte_count = CNT_W'(1);
        @(negedge clk);
        start = 1'b0; is_data = m;
      end
    end
    waitc = 0;
    while (busy && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    // R9 / R1: idle levels right when busy drops
    chk(!busy && lcd_cs_n && lcd_dc && lcd_sck && lcd_sdo, "R9 idle at end",
        {busy, lcd_cs_n, lcd_dc, lcd_sck, lcd_sdo}, 5'b01111);
    @(posedge clk);
    chk(rx_n == nexp, m ? "R7 byte count" : "R6 one command byte", rx_n, nexp);
    for (int i = 0; i < nexp && i < 16; i++) begin
      chk(rx_byte[i] == tx[i], "R4 byte msb first", rx_byte[i], tx[i]);
      chk(rx_dc[i] == m, m ? "R7 dc high" : "R6 dc low", rx_dc[i], m);
    end
    chk(phase_err == 0, "R5 phase lengths", phase_err, 0);
    chk(cs_rises == 1, "R7 single select window", cs_rises, 1);
    repeat (3) @(negedge clk);
    chk(!busy && lcd_cs_n, "R9 start during frame ignored", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R1: reset levels
    chk(!busy && lcd_cs_n && lcd_dc && lcd_sck && lcd_sdo && !in_ready, "R1 reset levels",
        {busy, lcd_cs_n, lcd_dc, lcd_sck, lcd_sdo}, 5'b01111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && lcd_cs_n && lcd_sck, "R1 idle after reset", {busy, lcd_cs_n, lcd_sck}, 3'b011);

    do_xfer(1'b1, 3, 1, 0, 1'b0, 1);   // R7 data burst, 00/FF
    do_xfer(1'b0, 5, 2, 0, 1'b0, 2);   // R6 command ignores count
    do_xfer(1'b1, 0, 1, 0, 1'b0, 0);   // R3 zero data
    do_xfer(1'b0, 0, 3, 0, 1'b0, 0);   // R3 zero command
    do_xfer(1'b1, 2, 0, 0, 1'b0, 0);   // R5 zero half period acts as one
    do_xfer(1'b1, 4, 3, 3, 1'b1, 0);   // R8 stalls, R9 start poke
    do_xfer(1'b1, 1, 5, 2, 1'b0, 2);   // R5 long phases
    for (int k = 0; k < 30; k++) begin
      do_xfer(1'($urandom), int'($urandom % 6), int'($urandom % 5),
              int'($urandom % 4), 1'($urandom), 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule